// File: doc/BRIEF.md
# SPI Target Peripheral with Processor Register Bus

This block lets a chip act as the target on an SPI link. An external controller drives the serial clock, the active-low select and the controller-to-target data line. The block returns data on its own serial output. Each select assertion carries exactly one word in each direction. The outgoing word comes from a transmit register that the local processor has loaded beforehand. The incoming word lands in a receive register that the processor reads.

The serial inputs are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The serial clock must therefore run below one quarter of the system clock.

Clock phase is mode 0:
- data is captured on the rising serial clock;
- the output advances on the falling serial clock;
- bits travel most significant first.

A small four-register bus gives the processor:
- the receive word;
- the transmit word;
- status flags for receive-ready, transmit-ready and a sticky overrun;
- separate interrupt enables for the receive-ready and transmit-ready conditions.

Top module: `spi_target_regs`

## Requirements
- R1: After reset, status (address 2: bit0 rx_ready, bit1 tx_ready, bit2 overrun) reads 0b010, irq_o is low and miso_en_o is low.
- R2: miso_en_o is high while a select is in progress and returns low after ss_n_i is released.
- R3: The loaded transmit word appears on miso_o most significant bit first. The first bit is valid before the first rising sclk_i, and the next bit follows each falling sclk_i.
- R4: mosi_i is captured on each rising sclk_i. After WORD_W bits the word is readable at address 0 and rx_ready is set.
- R5: A read of address 0 clears rx_ready.
- R6: A write to address 1 stores the transmit word and clears tx_ready. tx_ready is set again when that word is taken at the start of a select.
- R7: A select that begins while no transmit word is pending shifts out all zeros.
- R8: A word completing while rx_ready is still set overwrites the receive register and sets the sticky overrun flag. Writing a 1 to status bit2 clears that flag.
- R9: Releasing ss_n_i before WORD_W bits discards the partial word and leaves rx_ready and the receive register unchanged. The next select starts a fresh word.
- R10: irq_o is the OR of (rx_ready AND control bit0) and (tx_ready AND control bit1). The control register is at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| ss_n_i | input | 1 | Active-low select from the controller |
| mosi_i | input | 1 | Serial data into the target |
| miso_o | output | 1 | Serial data out of the target |
| miso_en_o | output | 1 | Output enable for the miso pad driver |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register address |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench instantiates the block with WORD_W set to 4 and BUS_W set to 8. At that width, every one of the 256 combinations of transmit word and received word can be swept through complete selects. Each combination checks the serial output bit order, the capture of the incoming word and the status flags after the transfer. The narrow word also keeps the directed cases short. These cases cover an aborted select, an empty transmit register, back-to-back words that cause an overrun, and each interrupt enable.

// File: rtl/spi_target_pkg.sv
package spi_target_pkg;
  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  localparam int STAT_RX_RDY = 0;
  localparam int STAT_TX_RDY = 1;
  localparam int STAT_OVR    = 2;
  localparam int CTRL_RX_IE  = 0;
  localparam int CTRL_TX_IE  = 1;
endpackage

// File: rtl/spi_target_sync.sv
module spi_target_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_target_shifter.sv
module spi_target_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              ss_n_s_i,
  input  logic              mosi_s_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tx_valid_i,
  output logic              start_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              miso_o,
  output logic              miso_en_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic              sclk_q, ss_n_q;
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q;
  logic              rise, fall, ss_act, start;

  assign rise   = sclk_s_i & ~sclk_q;
  assign fall   = ~sclk_s_i & sclk_q;
  assign ss_act = ~ss_n_s_i;
  assign start  = ss_act & ss_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      ss_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      ss_n_q <= ss_n_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!ss_act) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        tx_sh_q <= tx_valid_i ? tx_word_i : '0;
      end else if (busy_q && cnt_q != FULL_CNT) begin
        if (rise) begin
          rx_sh_q <= {rx_sh_q[WORD_W-2:0], mosi_s_i};
          cnt_q   <= cnt_q + 1'b1;
          done_q  <= (cnt_q == LAST_BIT);
        end else if (fall && cnt_q != '0) begin
          tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign start_o   = start;
  assign done_o    = done_q;
  assign rx_word_o = rx_sh_q;
  assign miso_o    = tx_sh_q[WORD_W-1];
  assign miso_en_o = busy_q;

  // R9
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R9
  one_word_per_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  empty_load_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !tx_valid_i) |=> (tx_sh_q == '0));
  // R2
  release_drops_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_n_s_i |=> !miso_en_o);
endmodule

// File: rtl/spi_target_regfile.sv
module spi_target_regfile
  import spi_target_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] tx_data_q, rx_data_q;
  logic              tx_full_q, rx_rdy_q, ovr_q, rx_ie_q, tx_ie_q;
  logic              rd_rx, wr_tx, wr_stat, wr_ctrl;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign rd_rx   = req_i & ~we_i & (addr_i == REG_RX);
  assign wr_tx   = req_i &  we_i & (addr_i == REG_TX);
  assign wr_stat = req_i &  we_i & (addr_i == REG_STAT);
  assign wr_ctrl = req_i &  we_i & (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_q <= '0;
      tx_full_q <= 1'b0;
    end else if (wr_tx) begin
      tx_data_q <= wdata_i[WORD_W-1:0];
      tx_full_q <= 1'b1;
    end else if (start_i) begin
      tx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (done_i) begin
        rx_data_q <= rx_word_i;
        rx_rdy_q  <= 1'b1;
      end else if (rd_rx) begin
        rx_rdy_q  <= 1'b0;
      end
      if (done_i && rx_rdy_q && !rd_rx) begin
        ovr_q <= 1'b1;
      end else if (wr_stat && wdata_i[STAT_OVR]) begin
        ovr_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ie_q <= 1'b0;
      tx_ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      rx_ie_q <= wdata_i[CTRL_RX_IE];
      tx_ie_q <= wdata_i[CTRL_TX_IE];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      REG_RX:   rdata_o[WORD_W-1:0] = rx_data_q;
      REG_TX:   rdata_o[WORD_W-1:0] = tx_data_q;
      REG_STAT: begin
        rdata_o[STAT_RX_RDY] = rx_rdy_q;
        rdata_o[STAT_TX_RDY] = ~tx_full_q;
        rdata_o[STAT_OVR]    = ovr_q;
      end
      REG_CTRL: begin
        rdata_o[CTRL_RX_IE] = rx_ie_q;
        rdata_o[CTRL_TX_IE] = tx_ie_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign tx_word_o  = tx_data_q;
  assign tx_valid_o = tx_full_q;
  assign irq_o      = (rx_rdy_q & rx_ie_q) | (~tx_full_q & tx_ie_q);

  // R5
  rx_read_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !done_i) |=> !rx_rdy_q);
  // R6
  tx_write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> tx_full_q);
  // R6
  tx_take_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_tx) |=> !tx_full_q);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !(wr_stat && wdata_i[STAT_OVR])) |=> ovr_q);
  // R4
  rx_done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rx_rdy_q && rx_data_q == $past(rx_word_i)));
endmodule

// File: rtl/spi_target_regs.sv
module spi_target_regs #(
  parameter int WORD_W = 8,
  parameter int BUS_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             ss_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_en_o,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [2:0]        pins_s;
  logic              start, done, tx_valid;
  logic [WORD_W-1:0] rx_word, tx_word;

  // bit order: {sclk, ss_n, mosi}; ss_n resets inactive
  spi_target_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sclk_i, ss_n_i, mosi_i}), .q_o(pins_s)
  );

  spi_target_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_s_i(pins_s[2]), .ss_n_s_i(pins_s[1]), .mosi_s_i(pins_s[0]),
    .tx_word_i(tx_word), .tx_valid_i(tx_valid),
    .start_o(start), .done_o(done), .rx_word_o(rx_word),
    .miso_o(miso_o), .miso_en_o(miso_en_o)
  );

  spi_target_regfile #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .start_i(start), .done_i(done), .rx_word_i(rx_word),
    .tx_word_o(tx_word), .tx_valid_o(tx_valid), .irq_o(irq_o)
  );

  initial begin
    // R3
    word_width_chk: assert (WORD_W >= 2 && WORD_W <= BUS_W && BUS_W >= 3);
  end

  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(irq_o)) |-> ($past(done) || $past(start) || $past(req_i && we_i)));
endmodule

// File: tb/spi_target_regs_bench.sv
module spi_target_regs_bench;
  localparam int W = 4;
  localparam int B = 8;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_en, req = 1'b0, we = 1'b0, irq;
  logic [1:0] addr = '0;
  logic [B-1:0] wdata = '0, rdata;
  int vecs = 0, errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_target_regs #(.WORD_W(W), .BUS_W(B)) u_spi_target_regs (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_en_o(miso_en), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [B-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [B-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  // nbits < W models an aborted select
  task automatic xfer(input logic [W-1:0] mo, input int nbits,
                      output logic [W-1:0] mi, output bit en_seen);
    mi = '0;
    @(negedge clk);
    ss_n = 1'b0;
    wclk(HALF);
    en_seen = miso_en;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[W-1-i];
      wclk(HALF);
      mi[W-1-i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    ss_n = 1'b1;
    wclk(HALF);
  endtask

  initial begin
    logic [B-1:0] d;
    logic [W-1:0] mi;
    bit en;
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    // R1 reset state
    reg_rd(2'd2, d); chk(d == 8'h02, "R1 status", d, 2);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(miso_en == 1'b0, "R1 miso_en", miso_en, 0);

    // R3 R4 R5 R6 sweep over every tx/rx pair
    for (int t = 0; t < 16; t++) begin
      for (int r = 0; r < 16; r++) begin
        reg_wr(2'd1, B'(t));
        reg_rd(2'd2, d);
        chk(d[1] == 1'b0, "R6 tx_ready cleared", d[1], 0);
        xfer(W'(r), W, mi, en);
        chk(en == 1'b1, "R2 miso_en during select", en, 1);
        chk(miso_en == 1'b0, "R2 miso_en after release", miso_en, 0);
        chk(mi == W'(t), "R3 miso word", mi, t);
        reg_rd(2'd2, d);
        chk(d == 8'h03, "R4 R6 status after word", d, 3);
        reg_rd(2'd0, d);
        chk(d == B'(r), "R4 rx word", d, r);
        reg_rd(2'd2, d);
        chk(d[0] == 1'b0, "R5 rx_ready cleared", d[0], 0);
      end
    end

    // R7 empty tx sends zeros
    xfer(4'h9, W, mi, en);
    chk(mi == 4'h0, "R7 zeros", mi, 0);
    reg_rd(2'd0, d);

    // R8 overrun
    xfer(4'h5, W, mi, en);
    xfer(4'hC, W, mi, en);
    reg_rd(2'd2, d); chk(d == 8'h07, "R8 overrun set", d, 7);
    reg_rd(2'd0, d); chk(d == 8'h0C, "R8 overwrite", d, 8'h0C);
    reg_rd(2'd2, d); chk(d == 8'h06, "R8 overrun sticky", d, 6);
    reg_wr(2'd2, 8'h04);
    reg_rd(2'd2, d); chk(d == 8'h02, "R8 overrun cleared", d, 2);

    // R9 abort after 2 bits
    reg_wr(2'd1, 8'h0A);
    xfer(4'h3, 2, mi, en);
    reg_rd(2'd2, d); chk(d == 8'h02, "R9 no rx_ready", d, 2);
    reg_rd(2'd0, d); chk(d == 8'h0C, "R9 rx unchanged", d, 8'h0C);
    xfer(4'h6, W, mi, en);
    chk(mi == 4'h0, "R9 R7 next select fresh", mi, 0);
    reg_rd(2'd0, d); chk(d == 8'h06, "R9 next word aligned", d, 6);

    // R10 interrupts
    reg_wr(2'd3, 8'h01);
    wclk(1); chk(irq == 1'b0, "R10 rx irq idle", irq, 0);
    xfer(4'h1, W, mi, en);
    chk(irq == 1'b1, "R10 rx irq", irq, 1);
    reg_rd(2'd0, d);
    wclk(1); chk(irq == 1'b0, "R10 rx irq cleared", irq, 0);
    reg_wr(2'd3, 8'h02);
    wclk(1); chk(irq == 1'b1, "R10 tx irq", irq, 1);
    reg_wr(2'd1, 8'h05);
    wclk(1); chk(irq == 1'b0, "R10 tx irq cleared", irq, 0);
    reg_rd(2'd3, d); chk(d == 8'h02, "R10 ctrl readback", d, 2);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule